// File: doc/BRIEF.md
# Nibble-Composed 8x8 Unsigned Multiplier

This block multiplies two unsigned 8-bit operands and returns their 16-bit product, with no clock and no storage. Each operand is cut into a high and a low 4-bit half. Four identical 4x4 array multipliers form the cross products. Each array is a square grid of cells, and every cell holds one AND gate for a partial-product bit and one full adder.

The two mixed products (high-by-low and low-by-high) are added first. The wider outer-product concatenation then absorbs that sum, weighted by sixteen. The whole product therefore needs two additions and not three. The lowest nibble of the low-by-low product is passed straight to the output. The final adder covers only the upper twelve bits.

The half width is a parameter. The operand width and product width are derived from it, and an elaboration check rejects unusable values. The block is meant to be dropped into a datapath as a purely combinational stage.

Top module: `split_array_mul`

## Requirements
- R1: For every pair of unsigned operands, `prod_o` equals the arithmetic product `a_i * b_i`, zero-extended to 16 bits.
- R2: The 4x4 array submodule returns the exact 8-bit product for all 256 pairs of 4-bit operands.
- R3: When either operand is zero, `prod_o` is zero.
- R4: When one operand is 1, `prod_o` equals the other operand zero-extended.
- R5: When bits [7:4] of both operands are zero, `prod_o[15:8]` is zero and `prod_o[7:0]` equals the product of the two low nibbles.
- R6: The largest product, 255*255 = 0xFE01, is produced exactly, and the final twelve-bit addition never carries out of bit 15.
- R7: When bits [3:0] of both operands are zero, `prod_o[7:0]` is zero and `prod_o[15:8]` equals the product of the two high nibbles.
- R8: The block is combinational: `prod_o` reflects new operand values within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Unsigned multiplicand |
| b_i | input | 8 | Unsigned multiplier |
| prod_o | output | 16 | Unsigned product |

## Verification
The bench targets the carry paths that a composite multiplier most easily breaks. The all-ones operands drive every row of every array and both adders to their full carry chains. A design that drops the carry out of the mixed-product sum, or misplaces the top-row carry of an array, would return a product short by a power of two. Operands with only high or only low nibbles set isolate a single array. If the arrays were swapped or the mixed sum were shifted by the wrong amount, nonzero bits would appear in the half of the product that must stay zero. The arrays are swept over all 256 nibble pairs, and the full block over all 65536 operand pairs, so a single miswired cell cannot hide.

// File: rtl/mul_pkg.sv
package mul_pkg;

   // one-bit full adder: returns {carry, sum}
   function automatic logic [1:0] full_add(input logic p, input logic q, input logic r);
      return {(p & q) | (r & (p ^ q)), p ^ q ^ r};
   endfunction

endpackage

// File: rtl/mul_cell.sv
module mul_cell
   import mul_pkg::*;
(
   input  logic x_bit,
   input  logic y_bit,
   input  logic sum_in,
   input  logic cy_in,
   output logic sum_out,
   output logic cy_out
);
   logic pp;
   assign pp = x_bit & y_bit;
   assign {cy_out, sum_out} = full_add(pp, sum_in, cy_in);
endmodule

// File: rtl/rc_add.sv
module rc_add
   import mul_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);
   if (W < 1) begin : g_bad_w
      $error("rc_add: W must be at least 1");
   end

   logic [W:0] cy;
   assign cy[0] = ci;

   for (genvar k = 0; k < W; k++) begin : g_bit
      assign {cy[k+1], s[k]} = full_add(x[k], y[k], cy[k]);
   end

   assign co = cy[W];
endmodule

// File: rtl/mul_array.sv
module mul_array #(
   parameter int W = 4
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [2*W-1:0] p
);
   if (W < 2 || W > 16) begin : g_bad_w
      $error("mul_array: W must lie in 2..16");
   end

   // row_s[j][i]: sum out of cell i in row j; row_c[j][i+1]: its carry out
   logic [W-1:0][W-1:0] row_s;
   logic [W-1:0][W:0]   row_c;

   for (genvar j = 0; j < W; j++) begin : g_row
      assign row_c[j][0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_col
         logic s_in;
         if (j == 0) begin : g_first
            assign s_in = 1'b0;
         end else if (i == W-1) begin : g_edge
            assign s_in = row_c[j-1][W];
         end else begin : g_inner
            assign s_in = row_s[j-1][i+1];
         end
         mul_cell u_cell (
            .x_bit  (x[i]),
            .y_bit  (y[j]),
            .sum_in (s_in),
            .cy_in  (row_c[j][i]),
            .sum_out(row_s[j][i]),
            .cy_out (row_c[j][i+1])
         );
      end
      if (j < W-1) begin : g_tap
         assign p[j] = row_s[j][0];
      end
   end

   assign p[2*W-2:W-1] = row_s[W-1];
   assign p[2*W-1]     = row_c[W-1][W];
endmodule

// File: rtl/split_array_mul.sv
module split_array_mul #(
   parameter int HALF_W = 4
) (
   input  logic [2*HALF_W-1:0] a_i,
   input  logic [2*HALF_W-1:0] b_i,
   output logic [4*HALF_W-1:0] prod_o
);
   localparam int OW = 2 * HALF_W;   // operand width
   localparam int PW = 2 * OW;       // product width
   localparam int UW = PW - HALF_W;  // width of the final addition
   localparam int PADW = UW - OW - 1;

   if (HALF_W < 2 || HALF_W > 16) begin : g_bad_half
      $error("split_array_mul: HALF_W must lie in 2..16");
   end

   logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;
   assign a_lo = a_i[HALF_W-1:0];
   assign a_hi = a_i[OW-1:HALF_W];
   assign b_lo = b_i[HALF_W-1:0];
   assign b_hi = b_i[OW-1:HALF_W];

   logic [OW-1:0] q_ll, q_hh, q_hl, q_lh;

   mul_array #(.W(HALF_W)) u_ll (.x(a_lo), .y(b_lo), .p(q_ll));
   mul_array #(.W(HALF_W)) u_hh (.x(a_hi), .y(b_hi), .p(q_hh));
   mul_array #(.W(HALF_W)) u_hl (.x(a_hi), .y(b_lo), .p(q_hl));
   mul_array #(.W(HALF_W)) u_lh (.x(a_lo), .y(b_hi), .p(q_lh));

   // first addition: the two mixed products
   logic [OW-1:0] mid_s;
   logic          mid_c;
   rc_add #(.W(OW)) u_mid (
      .x (q_hl),
      .y (q_lh),
      .ci(1'b0),
      .s (mid_s),
      .co(mid_c)
   );

   // second addition: mixed sum weighted by 2^HALF_W onto {hh, ll}
   logic [UW-1:0] up_x, up_y, fin_s;
   logic          fin_cy;
   assign up_x = {q_hh, q_ll[OW-1:HALF_W]};
   assign up_y = {{PADW{1'b0}}, mid_c, mid_s};

   rc_add #(.W(UW)) u_fin (
      .x (up_x),
      .y (up_y),
      .ci(1'b0),
      .s (fin_s),
      .co(fin_cy)
   );

   assign prod_o = {fin_s, q_ll[HALF_W-1:0]};
endmodule

// File: rtl/split_array_mul_chk.sv
module split_array_mul_chk #(
   parameter int HALF_W = 4
) (
   input logic [2*HALF_W-1:0] a_i,
   input logic [2*HALF_W-1:0] b_i,
   input logic [4*HALF_W-1:0] prod_o,
   input logic                fin_cy
);
   localparam int OW = 2 * HALF_W;
   localparam int PW = 2 * OW;

   always_comb begin
      if (!$isunknown({a_i, b_i})) begin
         a_r1_exact_product: assert (prod_o == PW'(a_i) * PW'(b_i));
         a_r3_zero_operand: assert (!(a_i == '0 || b_i == '0) || prod_o == '0);
         a_r4_unit_operand: assert (!(b_i == OW'(1)) || prod_o == PW'(a_i));
         a_r5_low_halves_only: assert (!(a_i[OW-1:HALF_W] == '0 && b_i[OW-1:HALF_W] == '0)
                                       || prod_o[PW-1:OW] == '0);
         a_r6_no_final_carry: assert (fin_cy == 1'b0);
         a_r7_high_halves_only: assert (!(a_i[HALF_W-1:0] == '0 && b_i[HALF_W-1:0] == '0)
                                        || prod_o[OW-1:0] == '0);
      end
   end
endmodule

bind split_array_mul split_array_mul_chk #(.HALF_W(HALF_W)) u_chk (
   .a_i   (a_i),
   .b_i   (b_i),
   .prod_o(prod_o),
   .fin_cy(fin_cy)
);

// File: tb/sim_split_array_mul.sv
module sim_split_array_mul;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;  // 50 MHz

   logic [7:0]  a, b;
   logic [15:0] prod;
   logic [3:0]  ax, ay;
   logic [7:0]  ap;

   split_array_mul #(.HALF_W(4)) u0 (.a_i(a), .b_i(b), .prod_o(prod));
   mul_array #(.W(4)) u1 (.x(ax), .y(ay), .p(ap));

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
      end
   endtask

   function automatic string tag_for(input int x, input int y);
      if (x == 0 || y == 0) return "R3";
      if (x == 1 || y == 1) return "R4";
      if (x < 16 && y < 16) return "R5";
      if ((x % 16) == 0 && (y % 16) == 0) return "R7";
      if (x == 255 && y == 255) return "R6";
      return "R1";
   endfunction

   task automatic apply(input int x, input int y);
      @(posedge clk);
      a = 8'(x);
      b = 8'(y);
      @(negedge clk);
      chk(tag_for(x, y), int'(prod), x * y);
   endtask

   initial begin
      int corner [5] = '{0, 1, 255, 15, 240};
      a = 8'd0; b = 8'd0; ax = 4'd0; ay = 4'd0;
      repeat (3) @(negedge clk);
      chk("R3", int'(prod), 0);  // idle state with zero operands
      rst_n = 1'b1;

      // R2: exhaustive sweep of the 4x4 array
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            @(posedge clk);
            ax = 4'(x);
            ay = 4'(y);
            @(negedge clk);
            chk("R2", int'(ap), x * y);
         end
      end

      // corner operand pairs
      foreach (corner[i]) begin
         foreach (corner[j]) apply(corner[i], corner[j]);
      end

      // R6: full-scale operands, explicit expected value 0xFE01
      apply(255, 255);
      chk("R6", int'(prod), 16'hFE01);

      // R5 / R7: isolated nibble arrays
      apply(13, 11);
      chk("R5", int'(prod[15:8]), 0);
      apply(8'hD0, 8'hB0);
      chk("R7", int'(prod[7:0]), 0);
      chk("R7", int'(prod[15:8]), 13 * 11);

      // R8: output follows inputs with no clock edge in between
      @(posedge clk);
      #2;
      a = 8'd200;
      b = 8'd3;
      #3;
      chk("R8", int'(prod), 600);
      a = 8'd17;
      #3;
      chk("R8", int'(prod), 51);

      // R1: exhaustive sweep of the composite multiplier
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) apply(x, y);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule